// File: doc/BRIEF.md
# Supply Supervisor Reset Sequencer

This block turns a supply-below-threshold comparator flag into an active-low reset for a low-power clock and memory device. The reset comes on as soon as the supply drops. It goes off only after the supply has been good for a fixed timeout, 250 ms by default. The timeout is counted in clock cycles, and the count comes from the clock frequency parameter. The comparator flag and the battery-mode flag are both asynchronous, so each passes through a two-stage synchronizer before use.

While reset is on, the block does two things to the serial interface. It sends a one-cycle abort strobe that ends any transfer in flight. It also holds a level signal that refuses new commands. A non-volatile write that has already started may run to completion, but only while the device is on main supply. If the supply dips while the device is in battery mode, reset stays on for as long as battery mode lasts, even once the supply has recovered. The timeout starts only after the device is back on main supply.

Top module: `supply_supervisor`

## Requirements
- R1: While the asynchronous power-on reset `rstN` is low, `resetN` is 0, `cmdBlock` is 1 and `commAbort` is 0.
- R2: When `supplyLow` rises while reset is off, `resetN` falls on the third rising clock edge after the change, and `cmdBlock` rises on the same edge.
- R3: When `supplyLow` falls with battery mode off, `resetN` rises on rising edge LIMIT+2 after the change. LIMIT = CLK_HZ*TIMEOUT_MS/1000 cycles.
- R4: While `supplyLow` stays 1, `resetN` stays 0 with no time limit.
- R5: If `supplyLow` rises again before the timeout ends, the count restarts from zero. A later recovery then needs the full LIMIT+2 edges again.
- R6: A supply dip while `batteryMode` is 1 keeps `resetN` at 0 for as long as `batteryMode` stays 1, whatever the supply does. After `batteryMode` falls with the supply good, `resetN` rises on rising edge LIMIT+3 after that change.
- R7: Raising `batteryMode` while the supply is good and reset is off leaves `resetN` at 1.
- R8: `commAbort` is 1 for exactly one cycle. It rises on the same edge on which `resetN` falls because of a supply dip.
- R9: `cmdBlock` is always the inverse of `resetN`.
- R10: `writeContinue` equals `writeBusy` while battery mode is off. It falls on the second rising edge after `batteryMode` rises, whatever the reset state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock of frequency CLK_HZ |
| rstN | input | 1 | Asynchronous power-on reset, active low |
| supplyLow | input | 1 | Asynchronous comparator flag, 1 = supply below threshold |
| batteryMode | input | 1 | Asynchronous flag, 1 = running from backup battery |
| writeBusy | input | 1 | Synchronous flag, 1 = non-volatile write in progress |
| resetN | output | 1 | Device reset, active low |
| commAbort | output | 1 | One-cycle strobe that ends a serial transfer in flight |
| cmdBlock | output | 1 | Level that refuses new serial commands |
| writeContinue | output | 1 | Permission for a running write to go on |

## Verification
The assertions assume that both asynchronous flags hold each level for at least two clock cycles, so that the synchronizer gives a clean edge. They also assume that `writeBusy` already belongs to the clock domain. The bench changes every input on the falling clock edge and holds each level for at least one full step of the vector table, which is three or more cycles, before it changes the input again. It runs with a small clock frequency parameter so that LIMIT is 100 cycles. Release instants can then be checked to the exact edge.

// File: rtl/supervisor_pkg.sv
package supervisor_pkg;
  typedef enum logic {ST_HOLD = 1'b0, ST_RUN = 1'b1} supState_t;

  typedef struct packed {
    logic cntClear;
    logic cntEnable;
  } cntStrobes_t;
endpackage

// File: rtl/supervisor_sync.sv
module supervisor_sync #(
  parameter int WIDTH = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] dIn,
  output logic [WIDTH-1:0] dOut
);
  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    logic stage1, stage2;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        stage1 <= RST_VAL[i];
        stage2 <= RST_VAL[i];
      end else begin
        stage1 <= dIn[i];
        stage2 <= stage1;
      end
    end
    assign dOut[i] = stage2;
  end
endmodule

// File: rtl/supervisor_datapath.sv
module supervisor_datapath
  import supervisor_pkg::*;
#(
  parameter int unsigned LIMIT = 8192
) (
  input  logic        clk,
  input  logic        rstN,
  input  cntStrobes_t strobes,
  output logic        cntDone
);
  localparam int CNT_W = (LIMIT > 1) ? $clog2(LIMIT) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(LIMIT - 1);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) cnt <= '0;
    else if (strobes.cntClear) cnt <= '0;
    else if (strobes.cntEnable && cnt != LAST) cnt <= cnt + 1'b1;
  end

  assign cntDone = (cnt == LAST);

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    cnt <= LAST); // R3
  AST_CNT_CLEARED: assert property (@(posedge clk) disable iff (!rstN)
    strobes.cntClear |=> cnt == '0); // R5
endmodule

// File: rtl/supervisor_control.sv
module supervisor_control
  import supervisor_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        supLowS,
  input  logic        batS,
  input  logic        cntDone,
  output cntStrobes_t strobes,
  output logic        resetN,
  output logic        commAbort,
  output logic        cmdBlock
);
  supState_t state, stateNext;
  logic batHold;
  logic canCount;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) batHold <= 1'b0;
    else if (supLowS && batS) batHold <= 1'b1;
    else if (!batS) batHold <= 1'b0;
  end

  assign canCount = !supLowS && !batHold;

  always_comb begin
    strobes.cntClear  = !canCount || (state == ST_RUN);
    strobes.cntEnable = canCount && (state == ST_HOLD);
  end

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_RUN:  if (supLowS) stateNext = ST_HOLD;
      ST_HOLD: if (strobes.cntEnable && cntDone) stateNext = ST_RUN;
      default: stateNext = ST_HOLD;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_HOLD;
      commAbort <= 1'b0;
    end else begin
      state     <= stateNext;
      commAbort <= (state == ST_RUN) && supLowS;
    end
  end

  assign resetN   = (state == ST_RUN);
  assign cmdBlock = (state == ST_HOLD);

  AST_ABORT_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    commAbort |=> !commAbort); // R8
  AST_ABORT_ON_ENTRY: assert property (@(posedge clk) disable iff (!rstN)
    $fell(resetN) |-> commAbort); // R8
  AST_LOW_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    supLowS |=> !resetN); // R4
  AST_BATT_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    batHold |-> !resetN); // R6
  AST_RELEASE_AT_LIMIT: assert property (@(posedge clk) disable iff (!rstN)
    $rose(resetN) |-> $past(cntDone)); // R3
endmodule

// File: rtl/supply_supervisor.sv
module supply_supervisor
  import supervisor_pkg::*;
#(
  parameter int unsigned CLK_HZ     = 32768,
  parameter int unsigned TIMEOUT_MS = 250
) (
  input  logic clk,
  input  logic rstN,
  input  logic supplyLow,
  input  logic batteryMode,
  input  logic writeBusy,
  output logic resetN,
  output logic commAbort,
  output logic cmdBlock,
  output logic writeContinue
);
  localparam longint unsigned CYC64 = (longint'(CLK_HZ) * longint'(TIMEOUT_MS)) / 1000;
  localparam int unsigned LIMIT = (CYC64 < 1) ? 1 : int'(CYC64);

  logic [1:0]  syncOut;
  logic        supLowS, batS, cntDone;
  cntStrobes_t strobes;

  supervisor_sync #(.WIDTH(2), .RST_VAL(2'b01)) u_sync (
    .clk(clk), .rstN(rstN),
    .dIn({batteryMode, supplyLow}),
    .dOut(syncOut)
  );
  assign supLowS = syncOut[0];
  assign batS    = syncOut[1];

  supervisor_control u_ctrl (
    .clk(clk), .rstN(rstN), .supLowS(supLowS), .batS(batS),
    .cntDone(cntDone), .strobes(strobes), .resetN(resetN),
    .commAbort(commAbort), .cmdBlock(cmdBlock)
  );

  supervisor_datapath #(.LIMIT(LIMIT)) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .cntDone(cntDone)
  );

  assign writeContinue = writeBusy && !batS;

  AST_WRITE_STOPS: assert property (@(posedge clk) disable iff (!rstN)
    $rose(batS) |-> !writeContinue); // R10
endmodule

// File: tb/supply_supervisor_tb.sv
module supply_supervisor_tb;
  localparam int CLK_HZ = 400;
  localparam int TMS    = 250;
  localparam int LIMIT  = CLK_HZ * TMS / 1000;

  typedef struct packed {
    logic        sup;
    logic        bat;
    logic        wb;
    int          edges;
    logic        expRst;
    logic        expWc;
    logic [15:0] tag;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 1'b0, 1'b1, 2,         1'b1, 1'b1, "R7"},  // idle, write busy
    '{1'b1, 1'b0, 1'b1, 2,         1'b1, 1'b1, "R2"},  // two edges: not yet
    '{1'b1, 1'b0, 1'b1, 1,         1'b0, 1'b1, "R2"},  // third edge: asserted
    '{1'b1, 1'b0, 1'b0, 300,       1'b0, 1'b0, "R4"},  // long low hold
    '{1'b0, 1'b0, 1'b0, LIMIT+1,   1'b0, 1'b0, "R3"},  // one edge early
    '{1'b0, 1'b0, 1'b0, 1,         1'b1, 1'b0, "R3"},  // release
    '{1'b0, 1'b1, 1'b1, 1,         1'b1, 1'b1, "R10"}, // battery in sync
    '{1'b0, 1'b1, 1'b1, 1,         1'b1, 1'b0, "R10"}, // write permission drops
    '{1'b0, 1'b1, 1'b1, 200,       1'b1, 1'b0, "R7"},  // battery, no dip
    '{1'b1, 1'b1, 1'b0, 3,         1'b0, 1'b0, "R6"},  // dip in battery
    '{1'b0, 1'b1, 1'b0, 3*LIMIT,   1'b0, 1'b0, "R6"},  // held despite supply
    '{1'b0, 1'b0, 1'b0, LIMIT+2,   1'b0, 1'b0, "R6"},  // back on main, early
    '{1'b0, 1'b0, 1'b0, 1,         1'b1, 1'b0, "R6"}   // release
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic supplyLow = 1'b1, batteryMode = 1'b0, writeBusy = 1'b0;
  logic resetN, commAbort, cmdBlock, writeContinue;
  int checks = 0, failures = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  supply_supervisor #(.CLK_HZ(CLK_HZ), .TIMEOUT_MS(TMS)) u_dut (
    .clk(clk), .rstN(rstN), .supplyLow(supplyLow), .batteryMode(batteryMode),
    .writeBusy(writeBusy), .resetN(resetN), .commAbort(commAbort),
    .cmdBlock(cmdBlock), .writeContinue(writeContinue)
  );

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%b expected=%b t=%0t", req, what, act, exp, $time);
    end
  endtask

  task automatic edges(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic report;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired actual=running expected=done");
      report();
    end
  end

  initial begin
    // R1: power-on state
    supplyLow = 1'b0;
    edges(3);
    chk("R1", "resetN", resetN, 1'b0);
    chk("R1", "cmdBlock", cmdBlock, 1'b1);
    chk("R1", "commAbort", commAbort, 1'b0);
    rstN = 1'b1;
    edges(LIMIT + 2);
    chk("R3", "resetN after power-on", resetN, 1'b1);

    for (int i = 0; i < NV; i++) begin
      supplyLow   = VECS[i].sup;
      batteryMode = VECS[i].bat;
      writeBusy   = VECS[i].wb;
      edges(VECS[i].edges);
      chk(string'(VECS[i].tag), "resetN", resetN, VECS[i].expRst);
      chk(string'(VECS[i].tag), "writeContinue", writeContinue, VECS[i].expWc);
      chk("R9", "cmdBlock", cmdBlock, !VECS[i].expRst);
    end

    // R8: abort strobe timing
    supplyLow = 1'b1;
    edges(2);
    chk("R8", "abort before", commAbort, 1'b0);
    edges(1);
    chk("R8", "abort pulse", commAbort, 1'b1);
    chk("R8", "resetN same edge", resetN, 1'b0);
    edges(1);
    chk("R8", "abort ends", commAbort, 1'b0);

    // R5: re-dip during timeout restarts count
    supplyLow = 1'b0;
    edges(LIMIT / 2);
    chk("R5", "mid timeout", resetN, 1'b0);
    supplyLow = 1'b1;
    edges(4);
    chk("R5", "abort none while held", commAbort, 1'b0);
    supplyLow = 1'b0;
    edges(LIMIT + 1);
    chk("R5", "restarted, early", resetN, 1'b0);
    edges(1);
    chk("R5", "restarted, release", resetN, 1'b1);

    // R10: write permission follows busy on main supply, even under reset
    writeBusy = 1'b1;
    supplyLow = 1'b1;
    edges(5);
    chk("R10", "write continues in reset", writeContinue, 1'b1);
    writeBusy = 1'b0;
    edges(1);
    chk("R10", "busy cleared", writeContinue, 1'b0);

    finished = 1'b1;
    report();
  end
endmodule